// File: doc/BRIEF.md
# Variable-Term Programmable Sum-of-Products Plane

This block is the logic core of a small programmable logic device. It takes a set of dedicated input signals and a set of feedback signals returned from the output cells. It presents each signal in true and inverted form as a column of a product-term array. Each product-term row ANDs together the columns that its configuration bits select. The rows are grouped into OR sums, one per output. The sums do not all have the same size: they start small at the two ends of the output range and grow by a fixed step toward the middle. Alongside the sums, each output has one row of its own that acts as its output-enable term. Two shared rows serve all outputs: one as an asynchronous reset term and one as a synchronous preset term.

All configuration (the array bits and a few mode bits per output cell) arrives over a serial port of one data bit and one shift enable. Once the full image has been shifted in, a done flag rises and the configuration is locked until reset. From the inputs to the sums and terms, the block is purely combinational. The output cells use its results together with their mode bits.

Top module: `sop_fuse_plane`

## Requirements
- R1: Signal s (s = 0 .. N_IN+N_FB-1) is dedicated input in_i[s] for s < N_IN and fb_i[s-N_IN] otherwise. Array column 2s carries signal s and column 2s+1 carries its inverse.
- R2: A product term is 1 exactly when every column whose configuration bit is 1 carries 1. A row with no bits set reads 1. A row that selects both columns of one signal reads 0.
- R3: Rows are laid out as follows. Row 0 is the shared reset term. Then, for each output k in ascending order, come one enable row and T_k sum rows. The last row is the shared preset term. With defaults, T_k for k = 0..9 is 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, which gives 132 rows.
- R4: sum_o[k] is the OR of the T_k sum rows of output k.
- R5: oe_o[k] equals the enable row of output k. ar_o equals row 0 and sp_o equals the last row.
- R6: The configuration image has TOTAL = rows*columns + N_OUT*CELL_W bits. Array bit (row r, column c) sits at image index N_OUT*CELL_W + r*columns + c, and cell bit j sits at index j. Bits enter MSB-first: the first accepted bit lands at index TOTAL-1, and the last one is cell_cfg_o[0].
- R7: A bit is accepted only on a rising clock edge where cfg_shift_en is 1. Cycles with the enable low change nothing.
- R8: load_done_o rises exactly after TOTAL accepted bits and then stays high. Once it is high, further shifts change no configuration bit.
- R9: Reset (rst_n low) clears every configuration bit and the bit count. After reset, every term and sum reads 1, cell_cfg_o reads 0 and load_done_o is 0, including when reset arrives partway through a load.
- R10: sum_o, oe_o, ar_o and sp_o follow changes on in_i and fb_i within the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| cfg_shift_en | input | 1 | Accept cfg_din on this clock edge |
| cfg_din | input | 1 | Serial configuration bit, MSB-first |
| in_i | input | N_IN (12) | Dedicated input signals |
| fb_i | input | N_FB (10) | Feedback signals from the output cells |
| sum_o | output | N_OUT (10) | OR sum per output |
| oe_o | output | N_OUT (10) | Output-enable term per output |
| ar_o | output | 1 | Shared asynchronous reset term |
| sp_o | output | 1 | Shared synchronous preset term |
| cell_cfg_o | output | N_OUT*CELL_W (20) | Mode bits for the output cells |
| load_done_o | output | 1 | Full image loaded, configuration locked |

## Verification
The bench builds the block with its default parameters: 12 inputs, 10 feedback signals, 10 outputs, sums of 8 rising by 2, and 2 cell bits per output. At that size the full 132-row, 44-column image and the uneven sum widths are exercised, including both 16-term middle sums and both 8-term end sums. Loading the full 5828-bit image with enable gaps puts the exact done point, the MSB-first placement of every row and cell bit, and the post-done lock within reach. A second image loaded after a reset in mid-load shows that the partial data was discarded.

// File: rtl/sop_pkg.sv
package sop_pkg;

   // Number of sum rows for output k: rises by t_step over the first half, mirrors over the second.
   function automatic int terms_of(int k, int n_out, int t_min, int t_step);
      int half;
      half = n_out / 2;
      if (k < half) return t_min + t_step * k;
      return t_min + t_step * (n_out - 1 - k);
   endfunction

   // First row (the enable row) of output k; row 0 is the shared reset term.
   function automatic int row_base(int k, int n_out, int t_min, int t_step);
      int b;
      b = 1;
      for (int j = 0; j < k; j++) b += 1 + terms_of(j, n_out, t_min, t_step);
      return b;
   endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
   parameter int NROW  = 132,
   parameter int NCOL  = 44,
   parameter int NCELL = 20
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           shift_en,
   input  logic                           din,
   output logic [NROW-1:0][NCOL-1:0]      fuse_o,
   output logic [NCELL-1:0]               cell_o,
   output logic                           done_o
);
   localparam int FW    = NROW * NCOL;
   localparam int TOTAL = FW + NCELL;
   localparam int CW    = $clog2(TOTAL + 1);
   localparam logic [CW-1:0] TOT_C = CW'(TOTAL);

   logic [FW-1:0]    flat_q;
   logic [NCELL-1:0] cell_q;
   logic [CW-1:0]    cnt_q;
   logic             take;

   assign done_o = (cnt_q == TOT_C);
   assign take   = shift_en && !done_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flat_q <= '0;
         cell_q <= '0;
         cnt_q  <= '0;
      end else if (take) begin
         cell_q <= {cell_q[NCELL-2:0], din};
         flat_q <= {flat_q[FW-2:0], cell_q[NCELL-1]};
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign fuse_o = flat_q;
   assign cell_o = cell_q;

   // R8: once the image is complete the flag never drops.
   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   // R8: a locked chain keeps every stored bit.
   p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> ($stable(flat_q) && $stable(cell_q)));

   // R7: no enable, no movement.
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> ($stable(cnt_q) && $stable(cell_q)));

   // R8: each accepted bit advances the count by one.
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/sop_pterm.sv
module sop_pterm #(
   parameter int NCOL = 44
) (
   input  logic [NCOL-1:0] cols_i,
   input  logic [NCOL-1:0] fuse_i,
   output logic            term_o
);
   // A selected column that carries 0 pulls the term low.
   assign term_o = &(cols_i | ~fuse_i);

   // R2: a row that selects a signal and its inverse can never be true.
   always_comb begin
      for (int s = 0; s < NCOL / 2; s++) begin
         if (fuse_i[2*s] && fuse_i[2*s+1])
            p_contra_r2: assert (!term_o);
      end
   end

endmodule

// File: rtl/sop_orsum.sv
module sop_orsum #(
   parameter int NT = 8
) (
   input  logic [NT-1:0] terms_i,
   output logic          sum_o
);
   generate
      if (NT == 1) begin : g_single
         assign sum_o = terms_i[0];
      end else begin : g_wide
         assign sum_o = |terms_i;
      end
   endgenerate

endmodule

// File: rtl/sop_fuse_plane.sv
module sop_fuse_plane #(
   parameter int N_IN   = 12,
   parameter int N_FB   = 10,
   parameter int N_OUT  = 10,
   parameter int T_MIN  = 8,
   parameter int T_STEP = 2,
   parameter int CELL_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_shift_en,
   input  logic                    cfg_din,
   input  logic [N_IN-1:0]         in_i,
   input  logic [N_FB-1:0]         fb_i,
   output logic [N_OUT-1:0]        sum_o,
   output logic [N_OUT-1:0]        oe_o,
   output logic                    ar_o,
   output logic                    sp_o,
   output logic [N_OUT*CELL_W-1:0] cell_cfg_o,
   output logic                    load_done_o
);
   import sop_pkg::*;

   localparam int NSIG  = N_IN + N_FB;
   localparam int NCOL  = 2 * NSIG;
   localparam int NROW  = row_base(N_OUT, N_OUT, T_MIN, T_STEP) + 1;
   localparam int NCELL = N_OUT * CELL_W;
   localparam int SP_ROW = NROW - 1;

   generate
      if (N_OUT < 2 || (N_OUT % 2) != 0) begin : g_bad_nout
         $error("N_OUT must be even and at least 2");
      end
      if (T_MIN < 1 || T_STEP < 0) begin : g_bad_terms
         $error("T_MIN must be positive and T_STEP non-negative");
      end
      if (CELL_W < 1 || N_IN < 1 || N_FB < 0) begin : g_bad_width
         $error("CELL_W and N_IN must be positive");
      end
   endgenerate

   logic [NSIG-1:0]            sig;
   logic [NCOL-1:0]            cols;
   logic [NROW-1:0][NCOL-1:0]  fuse;
   logic [NROW-1:0]            pt;

   assign sig = {fb_i, in_i};

   generate
      for (genvar s = 0; s < NSIG; s++) begin : g_col
         assign cols[2*s]   = sig[s];
         assign cols[2*s+1] = ~sig[s];
      end
   endgenerate

   sop_cfg_chain #(
      .NROW  (NROW),
      .NCOL  (NCOL),
      .NCELL (NCELL)
   ) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_shift_en),
      .din      (cfg_din),
      .fuse_o   (fuse),
      .cell_o   (cell_cfg_o),
      .done_o   (load_done_o)
   );

   generate
      for (genvar r = 0; r < NROW; r++) begin : g_row
         sop_pterm #(.NCOL(NCOL)) u_pt (
            .cols_i (cols),
            .fuse_i (fuse[r]),
            .term_o (pt[r])
         );
      end

      for (genvar k = 0; k < N_OUT; k++) begin : g_out
         localparam int B = row_base(k, N_OUT, T_MIN, T_STEP);
         localparam int T = terms_of(k, N_OUT, T_MIN, T_STEP);
         assign oe_o[k] = pt[B];
         sop_orsum #(.NT(T)) u_sum (
            .terms_i (pt[B+T:B+1]),
            .sum_o   (sum_o[k])
         );
      end
   endgenerate

   assign ar_o = pt[0];
   assign sp_o = pt[SP_ROW];

   // R9: an unloaded plane has no selected columns, so the shared terms read 1.
   p_blank_terms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_done_o && $past(!load_done_o) && (cell_cfg_o == '0) && (fuse == '0))
      |-> (ar_o && sp_o && (&oe_o) && (&sum_o)));

endmodule

// File: tb/sop_fuse_plane_tb_top.sv
module sop_fuse_plane_tb_top;
   localparam int NIN   = 12;
   localparam int NFB   = 10;
   localparam int NO    = 10;
   localparam int NSIG  = NIN + NFB;
   localparam int NCOL  = 2 * NSIG;
   localparam int NROW  = 132;
   localparam int NCELL = 20;
   localparam int TOTAL = NROW * NCOL + NCELL;

   typedef struct {
      logic [NO-1:0]    sum;
      logic [NO-1:0]    oe;
      logic             ar;
      logic             sp;
      logic [NCELL-1:0] cfg;
      logic             done;
      bit               data;
      string            note;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_shift_en = 1'b0;
   logic             cfg_din = 1'b0;
   logic [NIN-1:0]   in_i = '0;
   logic [NFB-1:0]   fb_i = '0;
   logic [NO-1:0]    sum_o;
   logic [NO-1:0]    oe_o;
   logic             ar_o;
   logic             sp_o;
   logic [NCELL-1:0] cell_cfg_o;
   logic             load_done_o;

   always #5 clk = ~clk;

   sop_fuse_plane dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_shift_en(cfg_shift_en),
      .cfg_din     (cfg_din),
      .in_i        (in_i),
      .fb_i        (fb_i),
      .sum_o       (sum_o),
      .oe_o        (oe_o),
      .ar_o        (ar_o),
      .sp_o        (sp_o),
      .cell_cfg_o  (cell_cfg_o),
      .load_done_o (load_done_o)
   );

   // Bench-side image and row map (R3 layout).
   logic [NCOL-1:0]  fz [NROW];
   logic [NCELL-1:0] cz;
   int tk [NO] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
   int base [NO];
   exp_t sbq [$];
   int n_chk = 0;
   int n_bad = 0;

   // R1 column meaning, R2 term rule.
   function automatic logic term_of(int r, logic [NSIG-1:0] sig);
      for (int c = 0; c < NCOL; c++) begin
         logic v;
         v = (c % 2 == 0) ? sig[c/2] : ~sig[c/2];
         if (fz[r][c] && !v) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic exp_t model(logic [NIN-1:0] a, logic [NFB-1:0] b, logic dn, bit data, string note);
      exp_t e;
      logic [NSIG-1:0] sig;
      sig = {b, a};
      for (int k = 0; k < NO; k++) begin
         e.oe[k] = term_of(base[k], sig);
         e.sum[k] = 1'b0;
         for (int t = 1; t <= tk[k]; t++) e.sum[k] |= term_of(base[k] + t, sig);
      end
      e.ar = term_of(0, sig);
      e.sp = term_of(NROW - 1, sig);
      e.cfg = cz;
      e.done = dn;
      e.data = data;
      e.note = note;
      return e;
   endfunction

   function automatic bit img_bit(int idx);
      if (idx >= NCELL) return fz[(idx - NCELL) / NCOL][(idx - NCELL) % NCOL];
      return cz[idx];
   endfunction

   task automatic apply(logic [NIN-1:0] a, logic [NFB-1:0] b, logic dn, bit data, string note);
      @(posedge clk); #1;
      cfg_shift_en = 1'b0;
      in_i = a;
      fb_i = b;
      sbq.push_back(model(a, b, dn, data, note));
   endtask

   task automatic apply_blank(logic [NIN-1:0] a, logic [NFB-1:0] b, string note);
      exp_t e;
      @(posedge clk); #1;
      cfg_shift_en = 1'b0;
      in_i = a;
      fb_i = b;
      e.sum = '1; e.oe = '1; e.ar = 1'b1; e.sp = 1'b1;
      e.cfg = '0; e.done = 1'b0; e.data = 1'b1; e.note = note;
      sbq.push_back(e);
   endtask

   task automatic shift1(bit b, bit en);
      @(posedge clk); #1;
      cfg_shift_en = en;
      cfg_din = b;
   endtask

   // R6 MSB-first order, R7 gaps with enable low carry junk data.
   task automatic load(int n);
      for (int k = 0; k < n; k++) begin
         int idx;
         bit b;
         idx = TOTAL - 1 - k;
         b = img_bit(idx);
         if (k % 5 == 0) shift1(~b, 1'b0);
         shift1(b, 1'b1);
      end
   endtask

   task automatic make_image(int dens);
      for (int r = 0; r < NROW; r++) begin
         fz[r] = '0;
         for (int n = 0; n < int'($urandom_range(dens, 1)); n++)
            fz[r][$urandom_range(NCOL - 1, 0)] = 1'b1;
      end
      cz = NCELL'($urandom);
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      cfg_shift_en = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic cmp(string req, string note, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (%s): actual %h expected %h", req, note, act, exp);
      end
   endtask

   // Monitor: pop and compare in the middle of the cycle after inputs settle.
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         cmp("R8", e.note, 32'(load_done_o), 32'(e.done));
         if (e.data) begin
            cmp("R4", e.note, 32'(sum_o), 32'(e.sum));
            cmp("R5", e.note, 32'(oe_o), 32'(e.oe));
            cmp("R5", e.note, 32'({ar_o, sp_o}), 32'({e.ar, e.sp}));
            cmp("R6", e.note, 32'(cell_cfg_o), 32'(e.cfg));
         end
      end
   end

   initial begin
      #1500000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int b;
      b = 1;
      for (int k = 0; k < NO; k++) begin
         base[k] = b;
         b += 1 + tk[k];
      end

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9 reset state, R10 outputs follow inputs with no edge between.
      apply_blank('0, '0, "R9 reset state");
      apply_blank('1, '1, "R9 R10 reset state all ones");
      apply_blank(12'h5a5, 10'h2c3, "R9 reset state mixed");

      // Image 1 with directed rows (R2, R3).
      make_image(3);
      for (int t = 1; t <= tk[0]; t++) begin
         fz[base[0] + t] = '0;
         fz[base[0] + t][0] = 1'b1;
         fz[base[0] + t][1] = 1'b1;      // R2 contradiction, so sum 0 stays 0
      end
      fz[base[9] + 3] = '0;              // R2 empty row, so sum 9 stays 1
      fz[0] = '0;
      fz[0][2] = 1'b1;                   // R1 column 2 = in_i[1]
      fz[0][5] = 1'b1;                   // R1 column 5 = ~in_i[2]
      fz[base[3]] = '0;
      fz[base[3]][24] = 1'b1;            // R1 column 24 = fb_i[0]
      fz[NROW - 1] = '0;
      fz[NROW - 1][43] = 1'b1;
      fz[NROW - 1][42] = 1'b1;           // preset row contradiction

      load(TOTAL - 1);
      apply('0, '0, 1'b0, 1'b0, "R8 one bit short of full image");
      shift1(img_bit(0), 1'b1);
      apply('0, '0, 1'b1, 1'b1, "R8 R6 done after full image");

      apply('1, '1, 1'b1, 1'b1, "R1 R2 R3 all ones");
      apply(12'h002, 10'h000, 1'b1, 1'b1, "R5 reset term true");
      apply(12'h006, 10'h001, 1'b1, 1'b1, "R5 reset term false, enable 3 true");
      for (int i = 0; i < NIN; i++)
         apply(NIN'(1) << i, '0, 1'b1, 1'b1, "R1 walking dedicated input");
      for (int i = 0; i < NFB; i++)
         apply('0, NFB'(1) << i, 1'b1, 1'b1, "R1 walking feedback");
      for (int i = 0; i < 30; i++)
         apply(NIN'($urandom), NFB'($urandom), 1'b1, 1'b1, "R3 R4 R10 random vectors");

      // R8 lock: shifting after done changes nothing.
      for (int i = 0; i < 40; i++) shift1(1'($urandom), 1'b1);
      for (int i = 0; i < 10; i++)
         apply(NIN'($urandom), NFB'($urandom), 1'b1, 1'b1, "R8 locked after done");

      // R9 reset partway through a second load.
      make_image(4);
      load(1000);
      do_reset();
      apply_blank('0, '1, "R9 mid-load reset");
      apply_blank(12'h0f0, 10'h155, "R9 mid-load reset mixed");

      // Second image from scratch (R6, R7).
      load(TOTAL);
      for (int i = 0; i < 30; i++)
         apply(NIN'($urandom), NFB'($urandom), 1'b1, 1'b1, "R6 R7 second image");

      while (sbq.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule